// File: doc/BRIEF.md
# Neuron Feed Sequencing Controller

This block feeds a bank of multiply-accumulate neurons for one layer stage of a convolutional network. A `start` pulse makes it read a three-word stage configuration block from a configuration memory. It then offers the decoded fields for one cycle to the downstream result-collection and calculation logic. After that it streams (data, weight) pairs from two synchronous memories into the neuron input FIFOs. The neurons work on the pairs; this block only decides which neuron receives which pair and in what order.

The layer mode sets the walk order and the address arithmetic. A finish flag goes out together with the last pair that belongs to a neuron, and the number of pairs per neuron comes from the loaded configuration. A full FIFO holds the current pair in place until that FIFO drains. A chain bit in the configuration makes the block fetch the next block, four words further on, and repeat the whole sequence. When the last stage ends, the block raises `done` for one cycle and goes idle.

Every memory read has one cycle of latency: a read issued in one cycle returns its word in the next cycle.

Top module: `nfs_feeder`

## Requirements
- R1: After reset no read, push, load or done is active. A `start` taken while idle issues configuration reads at block base +0, +1 and +2 on three consecutive cycles. The first block is at word 0.
- R2: Configuration word 0 packs the mode in bits [1:0], the kernel dimension K in [9:2], the neuron count N in [13:10], the chain bit in [14] and the input size S in [23:16]. Word 1 is the data base address and word 2 is the weight base address. Before the first pair of a stage, `fwd_load` pulses for one cycle with mode, K, N and S on the forward ports.
- R3: In convolution mode (code 0, and the unused code 3), neurons are served one after another, n = 0..N-1. Each neuron takes pairs i = 0..K*K-1, with data at dbase+n+i and weight at wbase+i.
- R4: In sub-sampling mode (code 1), the walk is neuron-major with K*K pairs per neuron. Data is at dbase+n*K*K+i and the weight is at wbase+n.
- R5: In fully connected mode (code 2), the walk is input-major: for each i = 0..S-1 every neuron n = 0..N-1 receives one pair. Data is at dbase+i and weight at wbase+n*S+i.
- R6: The finish flag of neuron n is raised only together with a push to n, and exactly on the last pair of that neuron (i = K*K-1, or i = S-1 in mode 2).
- R7: No push goes to a neuron whose full input is high. The stalled pair keeps a stable value, and every expected pair is delivered once, in order.
- R8: With the chain bit set, the block fetches the next configuration block at the previous base plus 4 after the stage's last pair, and runs it.
- R9: `done` is high for one cycle, on the last pair of a stage whose chain bit is clear, and the block is then idle. A `start` taken while busy is ignored.
- R10: At most one neuron is pushed per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin from configuration word 0 (ignored while busy) |
| cfg_rd | output | 1 | Configuration memory read enable |
| cfg_addr | output | CFG_AW | Configuration memory word address |
| cfg_rdata | input | 32 | Configuration word, one cycle after read |
| dat_rd | output | 1 | Data memory read enable |
| dat_addr | output | ADDR_W | Data memory address |
| dat_rdata | input | DATA_W | Data word, one cycle after read |
| wgt_rd | output | 1 | Weight memory read enable |
| wgt_addr | output | ADDR_W | Weight memory address |
| wgt_rdata | input | DATA_W | Weight word, one cycle after read |
| nrn_push | output | NUM_NEU | Per-neuron FIFO write strobe |
| nrn_fin | output | NUM_NEU | Per-neuron finish flag, valid with push |
| nrn_data | output | DATA_W | Data value of the pushed pair |
| nrn_wgt | output | DATA_W | Weight value of the pushed pair |
| nrn_full | input | NUM_NEU | Per-neuron FIFO full |
| fwd_load | output | 1 | One-cycle strobe for the forwarded fields |
| fwd_mode | output | 2 | Forwarded layer mode |
| fwd_kdim | output | 8 | Forwarded kernel dimension |
| fwd_nneu | output | 4 | Forwarded neuron count |
| fwd_insize | output | 8 | Forwarded input size |
| done | output | 1 | Last stage finished |

## Verification
The delicate collision is between the finish flag and backpressure. The pair that closes a neuron, or a whole stage, can meet a full FIFO on that same neuron, so the flag, the walk advance, the chain fetch and `done` all have to wait together. The bench sweeps every mode, kernel dimensions 1 to 3 and neuron counts 1 to 4, once with free FIFOs and once with a pseudo-random full pattern. The pattern lands stalls on closing pairs. Each pushed pair is compared against a sequence computed from the address formulas, and a single `done` per run is required. A chained run with a repeated `start` also checks that the last pair of one stage and the next configuration fetch do not overlap.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int CFG_W   = 32;
  localparam int MODE_FW = 2;
  localparam int KDIM_FW = 8;
  localparam int NEU_FW  = 4;
  localparam int SIZE_FW = 8;
  localparam int CNT_W   = 2 * KDIM_FW;

  typedef enum logic [MODE_FW-1:0] {
    MODE_CONV = 2'd0,
    MODE_SUBS = 2'd1,
    MODE_FC   = 2'd2,
    MODE_RSV  = 2'd3
  } layer_mode_e;

  typedef struct packed {
    logic [MODE_FW-1:0] mode;
    logic [KDIM_FW-1:0] kdim;
    logic [NEU_FW-1:0]  nneu;
    logic               chain;
    logic [SIZE_FW-1:0] insize;
  } stage_cfg_t;

  function automatic stage_cfg_t unpack_word0(input logic [CFG_W-1:0] w);
    stage_cfg_t c;
    c.mode   = w[1:0];
    c.kdim   = w[9:2];
    c.nneu   = w[13:10];
    c.chain  = w[14];
    c.insize = w[23:16];
    return c;
  endfunction

  function automatic logic [CNT_W-1:0] pairs_per_neuron(input stage_cfg_t c);
    if (c.mode == MODE_FC) return CNT_W'(c.insize);
    return CNT_W'(c.kdim) * CNT_W'(c.kdim);
  endfunction

  function automatic logic [31:0] data_offset(input logic [MODE_FW-1:0] mode,
                                              input logic [31:0] n, input logic [31:0] i,
                                              input logic [31:0] plen);
    case (mode)
      MODE_SUBS: return n * plen + i;
      MODE_FC:   return i;
      default:   return n + i;
    endcase
  endfunction

  function automatic logic [31:0] weight_offset(input logic [MODE_FW-1:0] mode,
                                                input logic [31:0] n, input logic [31:0] i,
                                                input logic [31:0] plen);
    case (mode)
      MODE_SUBS: return n;
      MODE_FC:   return n * plen + i;
      default:   return i;
    endcase
  endfunction
endpackage

// File: rtl/nfs_cfg_regs.sv
module nfs_cfg_regs
  import nfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_w0,
  input  logic             cap_w1,
  input  logic             cap_w2,
  input  logic [CFG_W-1:0] rdata,
  output stage_cfg_t       cfg,
  output logic [CFG_W-1:0] dat_base,
  output logic [CFG_W-1:0] wgt_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      dat_base <= '0;
      wgt_base <= '0;
    end else begin
      if (cap_w0) cfg      <= unpack_word0(rdata);
      if (cap_w1) dat_base <= rdata;
      if (cap_w2) wgt_base <= rdata;
    end
  end
endmodule

// File: rtl/nfs_walker.sv
module nfs_walker
  import nfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              input_major,
  input  logic [CNT_W-1:0]  plen,
  input  logic [NEU_FW-1:0] nneu,
  output logic [NEU_FW-1:0] n_idx,
  output logic [CNT_W-1:0]  i_idx,
  output logic              neuron_last,
  output logic              stage_last
);
  logic n_last;

  assign neuron_last = (i_idx == plen - CNT_W'(1));
  assign n_last      = (n_idx == nneu - NEU_FW'(1));
  assign stage_last  = neuron_last && n_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      n_idx <= '0;
      i_idx <= '0;
    end else if (step) begin
      if (input_major) begin
        if (n_last) begin
          n_idx <= '0;
          i_idx <= i_idx + CNT_W'(1);
        end else begin
          n_idx <= n_idx + NEU_FW'(1);
        end
      end else begin
        if (neuron_last) begin
          i_idx <= '0;
          n_idx <= n_idx + NEU_FW'(1);
        end else begin
          i_idx <= i_idx + CNT_W'(1);
        end
      end
    end
  end

  AST_TARGET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (n_idx < nneu)); // R10
endmodule

// File: rtl/nfs_pair_hold.sv
module nfs_pair_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dat_rdata,
  input  logic [DATA_W-1:0] wgt_rdata,
  output logic [DATA_W-1:0] pair_dat,
  output logic [DATA_W-1:0] pair_wgt
);
  logic              fresh;
  logic [DATA_W-1:0] held_dat;
  logic [DATA_W-1:0] held_wgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh    <= 1'b0;
      held_dat <= '0;
      held_wgt <= '0;
    end else begin
      fresh <= rd_issue;
      if (fresh) begin
        held_dat <= dat_rdata;
        held_wgt <= wgt_rdata;
      end
    end
  end

  assign pair_dat = fresh ? dat_rdata : held_dat;
  assign pair_wgt = fresh ? wgt_rdata : held_wgt;
endmodule

// File: rtl/nfs_feeder.sv
module nfs_feeder
  import nfs_pkg::*;
#(
  parameter int NUM_NEU = 4,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 16,
  parameter int CFG_AW  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               cfg_rd,
  output logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_rdata,
  output logic               dat_rd,
  output logic [ADDR_W-1:0]  dat_addr,
  input  logic [DATA_W-1:0]  dat_rdata,
  output logic               wgt_rd,
  output logic [ADDR_W-1:0]  wgt_addr,
  input  logic [DATA_W-1:0]  wgt_rdata,
  output logic [NUM_NEU-1:0] nrn_push,
  output logic [NUM_NEU-1:0] nrn_fin,
  output logic [DATA_W-1:0]  nrn_data,
  output logic [DATA_W-1:0]  nrn_wgt,
  input  logic [NUM_NEU-1:0] nrn_full,
  output logic               fwd_load,
  output logic [1:0]         fwd_mode,
  output logic [7:0]         fwd_kdim,
  output logic [3:0]         fwd_nneu,
  output logic [7:0]         fwd_insize,
  output logic               done
);
  localparam int BLOCK_STRIDE = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_CF0, S_CF1, S_CF2, S_CF3, S_LOAD, S_RD, S_PUSH
  } feed_state_e;

  feed_state_e        state;
  logic [CFG_AW-1:0]  blk_base;
  stage_cfg_t         cfg;
  logic [CFG_W-1:0]   dat_base;
  logic [CFG_W-1:0]   wgt_base;
  logic [NEU_FW-1:0]  n_idx;
  logic [CNT_W-1:0]   i_idx;
  logic [CNT_W-1:0]   plen;
  logic               neuron_last;
  logic               stage_last;
  logic [NUM_NEU-1:0] target_vec;
  logic               target_full;
  logic               push_fire;
  logic               stage_end;
  logic               walk_clear;

  // Internal events brought out for the checks
  assign push_fire  = (state == S_PUSH) && !target_full;
  assign stage_end  = push_fire && stage_last;
  assign walk_clear = (state == S_LOAD);
  assign plen       = pairs_per_neuron(cfg);

  nfs_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_w0   (state == S_CF1),
    .cap_w1   (state == S_CF2),
    .cap_w2   (state == S_CF3),
    .rdata    (cfg_rdata),
    .cfg      (cfg),
    .dat_base (dat_base),
    .wgt_base (wgt_base)
  );

  nfs_walker u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (walk_clear),
    .step        (push_fire),
    .input_major (cfg.mode == MODE_FC),
    .plen        (plen),
    .nneu        (cfg.nneu),
    .n_idx       (n_idx),
    .i_idx       (i_idx),
    .neuron_last (neuron_last),
    .stage_last  (stage_last)
  );

  nfs_pair_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (dat_rd),
    .dat_rdata (dat_rdata),
    .wgt_rdata (wgt_rdata),
    .pair_dat  (nrn_data),
    .pair_wgt  (nrn_wgt)
  );

  for (genvar g = 0; g < NUM_NEU; g++) begin : g_neu
    assign target_vec[g] = (n_idx == NEU_FW'(g));
    assign nrn_push[g]   = push_fire && target_vec[g];
    assign nrn_fin[g]    = push_fire && target_vec[g] && neuron_last;
  end
  assign target_full = |(nrn_full & target_vec);

  always_comb begin
    cfg_rd   = (state == S_CF0) || (state == S_CF1) || (state == S_CF2);
    cfg_addr = blk_base;
    if (state == S_CF1) cfg_addr = blk_base + CFG_AW'(1);
    if (state == S_CF2) cfg_addr = blk_base + CFG_AW'(2);
  end

  assign dat_rd   = (state == S_RD);
  assign wgt_rd   = (state == S_RD);
  assign dat_addr = ADDR_W'(dat_base + data_offset(cfg.mode, 32'(n_idx), 32'(i_idx), 32'(plen)));
  assign wgt_addr = ADDR_W'(wgt_base + weight_offset(cfg.mode, 32'(n_idx), 32'(i_idx), 32'(plen)));

  assign fwd_load   = (state == S_LOAD);
  assign fwd_mode   = cfg.mode;
  assign fwd_kdim   = cfg.kdim;
  assign fwd_nneu   = cfg.nneu;
  assign fwd_insize = cfg.insize;
  assign done       = stage_end && !cfg.chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      blk_base <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          blk_base <= '0;
          state    <= S_CF0;
        end
        S_CF0:  state <= S_CF1;
        S_CF1:  state <= S_CF2;
        S_CF2:  state <= S_CF3;
        S_CF3:  state <= S_LOAD;
        S_LOAD: state <= S_RD;
        S_RD:   state <= S_PUSH;
        S_PUSH: if (push_fire) begin
          if (!stage_last) begin
            state <= S_RD;
          end else if (cfg.chain) begin
            blk_base <= blk_base + CFG_AW'(BLOCK_STRIDE);
            state    <= S_CF0;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_CFG_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && $past(cfg_rd)) |-> (cfg_addr == $past(cfg_addr) + CFG_AW'(1))); // R1
  AST_LOAD_BEFORE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_load |=> (dat_rd && nrn_push == '0)); // R2
  AST_FIN_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (nrn_fin & ~nrn_push) == '0); // R6
  AST_NO_PUSH_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (nrn_push & nrn_full) == '0); // R7
  AST_PAIR_STABLE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH && target_full) |=> ($stable(nrn_data) && $stable(nrn_wgt))); // R7
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!dat_rd && !cfg_rd && !done)); // R9
  AST_ONE_NEURON: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nrn_push)); // R10
endmodule

// File: tb/sim_nfs_feeder.sv
module sim_nfs_feeder;
  localparam int NN = 4;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int CAW = 6;
  localparam int MAXE = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_rd, dat_rd, wgt_rd, fwd_load, done;
  logic [CAW-1:0] cfg_addr;
  logic [31:0] cfg_rdata = '0;
  logic [AW-1:0] dat_addr, wgt_addr;
  logic [DW-1:0] dat_rdata = '0, wgt_rdata = '0, nrn_data, nrn_wgt;
  logic [NN-1:0] nrn_push, nrn_fin, nrn_full = '0;
  logic [1:0] fwd_mode;
  logic [7:0] fwd_kdim, fwd_insize;
  logic [3:0] fwd_nneu;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] cfg_mem [16];
  bit bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  int exp_n [MAXE]; int exp_d [MAXE]; int exp_w [MAXE]; bit exp_f [MAXE];
  string exp_tag [MAXE];
  int exp_cnt, mon_idx;
  int st_mode [8]; int st_k [8]; int st_nn [8]; int st_in [8]; int st_start [8];
  int n_st, st_idx, cf_idx, done_cnt;
  bit prev_done = 0;

  always #4 clk = ~clk;

  nfs_feeder #(.NUM_NEU(NN), .ADDR_W(AW), .DATA_W(DW), .CFG_AW(CAW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .dat_rd(dat_rd), .dat_addr(dat_addr), .dat_rdata(dat_rdata),
    .wgt_rd(wgt_rd), .wgt_addr(wgt_addr), .wgt_rdata(wgt_rdata),
    .nrn_push(nrn_push), .nrn_fin(nrn_fin), .nrn_data(nrn_data), .nrn_wgt(nrn_wgt),
    .nrn_full(nrn_full), .fwd_load(fwd_load), .fwd_mode(fwd_mode), .fwd_kdim(fwd_kdim),
    .fwd_nneu(fwd_nneu), .fwd_insize(fwd_insize), .done(done));

  function automatic int dval(input int a); return (a * 37 + 11) & 16'hFFFF; endfunction
  function automatic int wval(input int a); return (a ^ 16'h02C5) & 16'hFFFF; endfunction

  // memory models: one cycle of read latency
  always @(posedge clk) begin
    if (cfg_rd) cfg_rdata <= cfg_mem[cfg_addr[3:0]];
    if (dat_rd) dat_rdata <= DW'(dval(int'(dat_addr)));
    if (wgt_rd) wgt_rdata <= DW'(wval(int'(wgt_addr)));
  end

  // backpressure pattern, changed just after each edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nrn_full = bp_en ? (lfsr[3:0] & lfsr[7:4]) : '0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected pair stream, built from the address formulas of R3/R4/R5
  task automatic add_stage(input int mode, input int k, input int nn, input int insz,
                           input bit chain, input int db, input int wb);
    int plen;
    string tag;
    cfg_mem[4*n_st]   = {8'h0, 8'(insz), 1'b0, chain, 4'(nn), 8'(k), 2'(mode)};
    cfg_mem[4*n_st+1] = 32'(db);
    cfg_mem[4*n_st+2] = 32'(wb);
    st_mode[n_st] = mode; st_k[n_st] = k; st_nn[n_st] = nn; st_in[n_st] = insz;
    st_start[n_st] = exp_cnt;
    n_st++;
    plen = (mode == 2) ? insz : k * k;
    tag = (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R3";
    if (mode == 2) begin
      for (int i = 0; i < plen; i++)
        for (int n = 0; n < nn; n++) begin
          exp_n[exp_cnt] = n; exp_d[exp_cnt] = dval((db + i) % (1 << AW));
          exp_w[exp_cnt] = wval((wb + n * plen + i) % (1 << AW));
          exp_f[exp_cnt] = (i == plen - 1); exp_tag[exp_cnt] = tag; exp_cnt++;
        end
    end else begin
      for (int n = 0; n < nn; n++)
        for (int i = 0; i < plen; i++) begin
          exp_n[exp_cnt] = n;
          exp_d[exp_cnt] = dval((db + ((mode == 1) ? n * plen + i : n + i)) % (1 << AW));
          exp_w[exp_cnt] = wval((wb + ((mode == 1) ? n : i)) % (1 << AW));
          exp_f[exp_cnt] = (i == plen - 1); exp_tag[exp_cnt] = tag; exp_cnt++;
        end
    end
  endtask

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (nrn_push != '0) begin
        int pn = -1;
        for (int g = 0; g < NN; g++) if (nrn_push[g]) pn = g;
        chk($countones(nrn_push) == 1, "R10", "pushes in one cycle", $countones(nrn_push), 1);
        if (mon_idx < exp_cnt) begin
          chk(pn == exp_n[mon_idx], exp_tag[mon_idx], "target neuron", pn, exp_n[mon_idx]);
          chk(int'(nrn_data) == exp_d[mon_idx], exp_tag[mon_idx], "data value", int'(nrn_data), exp_d[mon_idx]);
          chk(int'(nrn_wgt) == exp_w[mon_idx], exp_tag[mon_idx], "weight value", int'(nrn_wgt), exp_w[mon_idx]);
          chk((nrn_fin != '0) == exp_f[mon_idx], "R6", "finish flag", int'(nrn_fin != '0), int'(exp_f[mon_idx]));
        end else chk(0, "R7", "extra pair", mon_idx, exp_cnt);
        mon_idx++;
      end
      if ((nrn_push & nrn_full) != '0) chk(0, "R7", "push into full fifo", int'(nrn_push), 0);
      if ((nrn_fin & ~nrn_push) != '0) chk(0, "R6", "finish without push", int'(nrn_fin), 0);
      if (cfg_rd) begin
        chk(int'(cfg_addr) == 4 * (cf_idx / 3) + cf_idx % 3, "R8", "config address",
            int'(cfg_addr), 4 * (cf_idx / 3) + cf_idx % 3);
        cf_idx++;
      end
      if (fwd_load) begin
        if (st_idx < n_st) begin
          chk(int'(fwd_mode) == st_mode[st_idx] && int'(fwd_kdim) == st_k[st_idx] &&
              int'(fwd_nneu) == st_nn[st_idx] && int'(fwd_insize) == st_in[st_idx],
              "R2", "forwarded fields (mode)", int'(fwd_mode), st_mode[st_idx]);
          chk(mon_idx == st_start[st_idx], "R2", "load before stage pairs", mon_idx, st_start[st_idx]);
        end else chk(0, "R8", "extra stage load", st_idx, n_st);
        st_idx++;
      end
      if (done) begin
        done_cnt++;
        if (prev_done) chk(0, "R9", "done wider than one cycle", 2, 1);
      end
      prev_done = done;
    end
  end

  task automatic clear_plan();
    exp_cnt = 0; n_st = 0; mon_idx = 0; st_idx = 0; cf_idx = 0; done_cnt = 0;
  endtask

  task automatic run_plan(input bit kick_again);
    int cyc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (kick_again) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (done_cnt == 0 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    chk(mon_idx == exp_cnt, "R7", "pairs delivered", mon_idx, exp_cnt);
    chk(st_idx == n_st, "R8", "stages run", st_idx, n_st);
    chk(!dat_rd && !cfg_rd && nrn_push == '0, "R9", "idle after done", int'(dat_rd), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++) cfg_mem[a] = '0;
    clear_plan();
    repeat (3) @(negedge clk);
    // R1: quiet while in reset and idle
    chk(!cfg_rd && !dat_rd && !wgt_rd && nrn_push == '0 && !done && !fwd_load, "R1", "reset outputs", int'(cfg_rd), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cfg_rd && !dat_rd && nrn_push == '0 && !done, "R1", "idle outputs", int'(dat_rd), 0);

    // sweep: every mode, K 1..3, N 1..4, free and backpressured FIFOs
    for (int bp = 0; bp < 2; bp++)
      for (int m = 0; m < 3; m++)
        for (int k = 1; k <= 3; k++)
          for (int nn = 1; nn <= NN; nn++) begin
            bp_en = bp[0];
            clear_plan();
            add_stage(m, k, nn, k + 2, 1'b0, 16 * k + nn, 300 + 40 * m);
            run_plan(1'b0);
          end

    // R8 chain of three stages, last one in mode 3; R9 second start while busy
    bp_en = 1'b1;
    clear_plan();
    add_stage(0, 1, 4, 0, 1'b1, 20, 600);
    add_stage(2, 0, 2, 3, 1'b1, 1000, 900);
    add_stage(3, 2, 1, 0, 1'b0, 50, 700);
    run_plan(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule